// File: doc/BRIEF.md
# Serial Two's Complement Sequencer

This block negates an 8-bit operand one bit per clock cycle instead of inverting the word and adding one. A START strobe captures the operand into a rotating register. The register then rotates right eight times. On each rotation the bit leaving the least significant end re-enters at the most significant end. That bit is complemented once a 1 has already left the register on an earlier rotation. After the eighth rotation the register holds the two's complement of the operand, and DONE is raised.

The design has a data unit and a control unit. The data unit holds the rotating register, a sticky invert flag and a shift counter. The control unit is a four-state machine: idle, load, shift and finished. It drives the data unit through a small bundle of strobes. It reads the bit that is about to leave the register and the counter's last-shift indication. DONE stays high, and the result stays frozen, for as long as START is held. Releasing START returns the block to idle, ready for the next operand.

Top module: `serialNegator`

## Requirements
- R1: While reset is asserted and after its release, `done` is 0 and `dataOut` is 0 until the first load.
- R2: When `done` rises, `dataOut` equals (256 - operand) mod 256. The operand is the value on `dataIn` during the load cycle.
- R3: Let edge N be the rising edge that samples `start` high in idle. Then `done` is 0 after edges N+1 through N+8 and is 1 after edge N+9. This is one load cycle followed by eight shift cycles.
- R4: Every operation performs exactly one parallel load followed by exactly eight shift cycles before `done` rises.
- R5: `dataOut` keeps the result unchanged while `done` is high and after the return to idle, until the next load.
- R6: `done` stays high while `start` stays high. The first rising edge that samples `start` low while `done` is high clears `done`.
- R7: A `start` pulse during the load or shift cycles changes neither the result nor the cycle on which `done` rises.
- R8: An operand of 8'h00 yields 8'h00, and an operand of 8'h80 yields 8'h80.
- R9: Back-to-back operations are independent. The invert flag and the shift counter are cleared in idle, so each result depends only on its own operand.
- R10: After the load edge, `dataOut` equals the operand. After each shift edge, `dataOut` is the previous value rotated right by one. The new bit 7 is the old bit 0, complemented exactly when a 1 left bit 0 on an earlier shift of the same operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| start | input | 1 | Begins an operation from idle; held high to keep the result flagged |
| dataIn | input | 8 | Operand, sampled in the load cycle |
| dataOut | output | 8 | Rotating register contents; the negated operand once `done` is high |
| done | output | 1 | High from the end of the eighth shift until `start` is released |

## Verification
Two events can land on the same shift edge: the invert flag being set by a 1 leaving bit 0, and that same bit being written back into bit 7. The written-back bit must use the flag's old value, so it stays uncomplemented. Operands whose first 1 sits at bit 0, bit 7 or in between provoke this, including 8'h01 and 8'h80. The bench judges each intermediate register value against its own bit-serial model after every shift. A second collision puts a `start` pulse on the eighth shift cycle, the cycle in which the counter ends the operation. The bench checks that `done` still rises on the expected edge and falls on the next one.

// File: rtl/negPkg.sv
package negPkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_LOAD = 2'b11
  } regMode_e;

  typedef struct packed {
    regMode_e mode;
    logic     clrCount;
    logic     clrInvert;
    logic     setInvert;
  } ctrlBus_t;

endpackage

// File: rtl/negDatapath.sv
module negDatapath
  import negPkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlBus_t         ctrl,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             bitFlag,
  output logic             lastShift
);

  logic [WIDTH-1:0] shReg;
  logic             invFlag;
  logic [CNT_W-1:0] shiftCount;

  // rotating register: bit leaving LSB re-enters at MSB, complemented once armed
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      shReg <= '0;
    end else begin
      case (ctrl.mode)
        MODE_LOAD: shReg <= dataIn;
        MODE_SHR:  shReg <= {shReg[0] ^ invFlag, shReg[WIDTH-1:1]};
        default:   shReg <= shReg;
      endcase
    end
  end

  // sticky invert flag, asynchronously cleared by reset
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      invFlag <= 1'b0;
    end else if (ctrl.clrInvert) begin
      invFlag <= 1'b0;
    end else if (ctrl.setInvert) begin
      invFlag <= 1'b1;
    end
  end

  // shift counter
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      shiftCount <= '0;
    end else if (ctrl.clrCount) begin
      shiftCount <= '0;
    end else if (ctrl.mode == MODE_SHR) begin
      shiftCount <= shiftCount + 1'b1;
    end
  end

  assign dataOut   = shReg;
  assign bitFlag   = shReg[0];
  assign lastShift = (shiftCount == CNT_W'(WIDTH - 1));

endmodule

// File: rtl/negControl.sv
module negControl
  import negPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     bitFlag,
  input  logic     lastShift,
  output ctrlBus_t ctrl,
  output logic     done
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_LOAD  = 2'b01,
    ST_SHIFT = 2'b10,
    ST_FIN   = 2'b11
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState      = state;
    ctrl.mode      = MODE_HOLD;
    ctrl.clrCount  = 1'b0;
    ctrl.clrInvert = 1'b0;
    ctrl.setInvert = 1'b0;
    case (state)
      ST_IDLE: begin
        ctrl.clrCount  = 1'b1;
        ctrl.clrInvert = 1'b1;
        if (start) nextState = ST_LOAD;
      end
      ST_LOAD: begin
        ctrl.mode = MODE_LOAD;
        nextState = ST_SHIFT;
      end
      ST_SHIFT: begin
        ctrl.mode      = MODE_SHR;
        ctrl.setInvert = bitFlag;
        if (lastShift) nextState = ST_FIN;
      end
      ST_FIN: begin
        if (!start) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign done = (state == ST_FIN);

endmodule

// File: rtl/serialNegator.sv
module serialNegator
  import negPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             done
);

  ctrlBus_t ctrlBus;
  logic     bitFlag;
  logic     lastShift;
  logic     loadStb;
  logic     shiftStb;

  negControl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .bitFlag   (bitFlag),
    .lastShift (lastShift),
    .ctrl      (ctrlBus),
    .done      (done)
  );

  negDatapath #(.WIDTH(WIDTH)) u_data (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrlBus),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .bitFlag   (bitFlag),
    .lastShift (lastShift)
  );

  assign loadStb  = (ctrlBus.mode == MODE_LOAD);
  assign shiftStb = (ctrlBus.mode == MODE_SHR);

endmodule

// File: rtl/negChecker.sv
module negChecker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] dataOut,
  input logic             done,
  input logic             loadStb,
  input logic             shiftStb
);

  localparam int SC_W = $clog2(WIDTH) + 2;

  logic [WIDTH-1:0] captured;
  logic [WIDTH-1:0] expNeg;
  logic [SC_W-1:0]  shiftSeen;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      captured  <= '0;
      shiftSeen <= '0;
    end else if (loadStb) begin
      captured  <= dataIn;
      shiftSeen <= '0;
    end else if (shiftStb && shiftSeen != '1) begin
      shiftSeen <= shiftSeen + 1'b1;
    end
  end

  assign expNeg = ~captured + 1'b1;

  // R2
  result_value_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> dataOut == expNeg);

  // R4
  shift_total_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> shiftSeen == SC_W'(WIDTH));

  // R4
  load_then_shift_chk: assert property (@(posedge clk) disable iff (rst)
    loadStb |=> shiftStb);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $stable(dataOut));

  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> !$past(start));

  // R6
  done_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> done);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |-> (!done && dataOut == '0));

endmodule

bind serialNegator negChecker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .dataIn   (dataIn),
  .dataOut  (dataOut),
  .done     (done),
  .loadStb  (loadStb),
  .shiftStb (shiftStb)
);

// File: tb/test_serialNegator.sv
`timescale 1ns/1ps
module test_serialNegator;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [7:0] dataIn;
  logic [7:0] dataOut;
  logic       done;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  reported = 1'b0;

  always #5 clk = ~clk;

  serialNegator #(.WIDTH(8)) i_serialNegator (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .done    (done)
  );

  // {operand, expected negation}
  localparam logic [15:0] VECS [10] = '{
    16'h4AB6, 16'h01FF, 16'hFF01, 16'h0000, 16'h8080,
    16'h7F81, 16'h02FE, 16'hA55B, 16'h10F0, 16'hC040
  };

  task automatic check(input bit ok, input string req,
                       input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    end
  endtask

  // One operation. pulseAt: shift index (1..8) carrying a stray start pulse, 0 for none.
  task automatic runOp(input logic [7:0] val, input logic [7:0] expRes, input int pulseAt);
    logic [7:0] cur;
    logic       inv;
    @(negedge clk); dataIn = val; start = 1'b1;
    @(negedge clk); start = 1'b0;             // edge N sampled start
    @(negedge clk);                           // load edge N+1
    check(dataOut == val, "R10 load", dataOut, val);
    check(done == 1'b0, "R3 early", {7'b0, done}, 8'h00);
    cur = val;
    inv = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      start = (k == pulseAt);                 // R7 stray pulse
      @(negedge clk);
      start = 1'b0;
      cur = {cur[0] ^ inv, cur[7:1]};
      inv = inv | val[k-1];
      check(dataOut == cur, "R10 shift", dataOut, cur);
      if (k < 8) check(done == 1'b0, "R3 early", {7'b0, done}, 8'h00);
    end
    check(done == 1'b1, "R3 done edge", {7'b0, done}, 8'h01);
    check(dataOut == expRes, "R2 result", dataOut, expRes);
    check(dataOut == 8'(9'h100 - {1'b0, val}), "R2 model", dataOut, 8'(9'h100 - {1'b0, val}));
    @(negedge clk);
    check(done == 1'b0, "R6 release", {7'b0, done}, 8'h00);
    check(dataOut == expRes, "R5 idle hold", dataOut, expRes);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    start = 1'b0;
    dataIn = 8'h00;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 reset done", {7'b0, done}, 8'h00);
    check(dataOut == 8'h00, "R1 reset data", dataOut, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check(dataOut == 8'h00 && !done, "R1 after reset", dataOut, 8'h00);

    // vector table, back to back (R9)
    foreach (VECS[i]) runOp(VECS[i][15:8], VECS[i][7:0], 0);
    check(1'b1, "R9 sequence ran", 8'h00, 8'h00);

    // R8 corner cases
    runOp(8'h00, 8'h00, 0);
    runOp(8'h80, 8'h80, 0);

    // R7 stray start pulses in shifting, including the last shift
    runOp(8'h4A, 8'hB6, 3);
    runOp(8'h01, 8'hFF, 8);
    runOp(8'h80, 8'h80, 1);

    // R6 / R5: hold start high through the whole operation
    @(negedge clk); dataIn = 8'h36; start = 1'b1;
    repeat (9) @(negedge clk);
    check(done == 1'b0, "R3 held start early", {7'b0, done}, 8'h00);
    @(negedge clk);
    check(done == 1'b1, "R6 held start done", {7'b0, done}, 8'h01);
    check(dataOut == 8'hCA, "R2 held start result", dataOut, 8'hCA);
    dataIn = 8'h11;
    repeat (3) begin
      @(negedge clk);
      check(done == 1'b1, "R6 done kept", {7'b0, done}, 8'h01);
      check(dataOut == 8'hCA, "R5 done hold", dataOut, 8'hCA);
    end
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R6 done cleared", {7'b0, done}, 8'h00);
    repeat (2) @(negedge clk);
    check(done == 1'b0 && dataOut == 8'hCA, "R5 idle no restart", dataOut, 8'hCA);

    // R9: after a heavy-invert operand, a following zero must stay zero
    runOp(8'h01, 8'hFF, 0);
    runOp(8'h00, 8'h00, 0);

    summary();
    $finish;
  end

endmodule